// File: doc/BRIEF.md
# UART Interrupt Source Identifier

This block gathers every interrupt condition of one serial channel, picks the most urgent pending one and presents it as an 8-bit status byte, together with an active-low pending line for the interrupt controller. Five conditions arrive as live levels from the surrounding channel logic: line error, receive data ready, receive timeout, transmit holding empty and modem status. Three more arrive as one-cycle event pulses that the block latches itself: a flow-control character match, a change on the modem control outputs and a change on the modem control inputs. Each latched event has its own clearing rule. A flow-control match stays set until an Xon character is seen. An output change clears on a read of the status byte. An input change clears on a read of the modem status register.

The block also holds the FIFO control byte. It qualifies writes to that byte on its enable bit and turns the receive-FIFO reset bit into a single-cycle clear pulse for the FIFO pointers. The enable bit is mirrored into the top two bits of the status byte. The status byte is registered, so it follows its sources by one clock. A read always returns the value that was present before the clear caused by that read.

Top module: `uart_irq_ident`

## Requirements
- R1: `irq_n` and bit 0 of `isr_byte` are 1 when no enabled source is pending and 0 when one is. After reset, `isr_byte` is 0x01 and `fcr_cfg` is 0x00.
- R2: Bits 5:0 of `isr_byte` encode the selected source as follows: line error 000110, receive ready 000100, receive timeout 001100, transmit empty 000010, modem status 000000, flow-control match 010000, modem change 100000, none 000001.
- R3: Priority runs from line error (highest), through receive ready, receive timeout, transmit empty, modem status and flow-control match, to modem change (lowest). Only the highest active source is encoded. A change of the sources shows in `isr_byte` on the clock edge after it occurs.
- R4: `src_en[k]` enables the source at priority position k (bit 0 is line error, bit 6 is modem change). A source whose enable bit is 0 is never encoded.
- R5: While `ext_en` is 0, the flow-control match source and the modem change source are never encoded, even when they are latched.
- R6: A flow-control match pulse sets a flag that stays set through any register read and clears only on an Xon pulse. An Xon pulse in the same cycle as a match pulse clears the flag.
- R7: An output-change pulse sets a flag that a status read (`stat_rd`) clears. The byte seen in the read cycle still shows that source.
- R8: An input-change pulse sets a flag that only a modem status read (`msr_rd`) clears. Either change flag raises the modem-change source.
- R9: A change pulse in the same cycle as the read that clears its flag leaves the flag set.
- R10: Bits 7:6 of `isr_byte` are 11 while `fcr_cfg[0]` is 1 and 00 while it is 0.
- R11: A write with `fcr_wdata[0]` equal to 1 loads all of `fcr_cfg`. A write with `fcr_wdata[0]` equal to 0 clears only bit 0 and leaves bits 7:2 unchanged.
- R12: A qualified write with bit 1 set raises `rx_fifo_clr` (which is `fcr_cfg[1]`) for exactly one cycle. An unqualified write never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lvl_line | input | 1 | Line error condition (level) |
| lvl_rxrdy | input | 1 | Receive data ready (level) |
| lvl_rxtmo | input | 1 | Receive timeout (level) |
| lvl_txe | input | 1 | Transmit holding empty (level) |
| lvl_modem | input | 1 | Modem status condition (level) |
| ev_match | input | 1 | Flow-control character match pulse |
| ev_xon | input | 1 | Xon character received pulse |
| ev_out_chg | input | 1 | Modem output change pulse |
| ev_in_chg | input | 1 | Modem input change pulse |
| src_en | input | 7 | Per-source enables, bit k = priority position k |
| ext_en | input | 1 | Enables the two extended sources |
| stat_rd | input | 1 | Status byte read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write data |
| isr_byte | output | 8 | Interrupt status byte |
| irq_n | output | 1 | Interrupt pending, active low |
| fcr_cfg | output | 8 | Current FIFO control byte |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO pointer clear |

## Verification
Two cases can fall in the same clock cycle: a read strobe that clears a change flag, and a new change pulse for that same flag. Likewise, an Xon pulse can arrive together with a match pulse. The bench drives each pair in one cycle. It then judges the outcome one and two edges later: the flag must survive the read, and it must give way to Xon. It also checks that the byte sampled during a clearing read still names the cleared source.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int NUM_LVL   = 7;
   localparam int EXT_FIRST = 5;
   localparam int CODE_W    = 6;

   localparam logic [CODE_W-1:0] C_LINE  = 6'b000110;
   localparam logic [CODE_W-1:0] C_RXRDY = 6'b000100;
   localparam logic [CODE_W-1:0] C_RXTMO = 6'b001100;
   localparam logic [CODE_W-1:0] C_TXE   = 6'b000010;
   localparam logic [CODE_W-1:0] C_MODEM = 6'b000000;
   localparam logic [CODE_W-1:0] C_SFC   = 6'b010000;
   localparam logic [CODE_W-1:0] C_CHG   = 6'b100000;
   localparam logic [CODE_W-1:0] C_NONE  = 6'b000001;

   function automatic logic [CODE_W-1:0] lvl_code(input int idx);
      case (idx)
         0: lvl_code = C_LINE;
         1: lvl_code = C_RXRDY;
         2: lvl_code = C_RXTMO;
         3: lvl_code = C_TXE;
         4: lvl_code = C_MODEM;
         5: lvl_code = C_SFC;
         6: lvl_code = C_CHG;
         default: lvl_code = C_NONE;
      endcase
   endfunction
endpackage

// File: rtl/irq_flag.sv
module irq_flag #(
   parameter bit CLR_WINS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_n;

   generate
      if (CLR_WINS) begin : g_clr_wins
         always_comb q_n = clr_i ? 1'b0 : (set_i ? 1'b1 : q_o);
      end else begin : g_set_wins
         always_comb q_n = set_i ? 1'b1 : (clr_i ? 1'b0 : q_o);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= q_n;
   end

   // R6 R7 R8: a set flag holds until its clear strobe
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      q_o && !clr_i |=> q_o);
   // R9: in the set-wins variant a set always lands
   p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i && !(CLR_WINS && clr_i) |=> q_o);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
   import uart_irq_pkg::*;
#(
   parameter int N = NUM_LVL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      req,
   output logic [CODE_W-1:0] code_o
);
   generate
      if (N != NUM_LVL) begin : g_bad_n
         $error("irq_prio_enc: N must equal the number of priority levels");
      end
   endgenerate

   logic [CODE_W-1:0] sel;

   always_comb begin
      sel = C_NONE;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) sel = lvl_code(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) code_o <= C_NONE;
      else        code_o <= sel;
   end

   // R3: the top level always wins on the next edge
   p_top_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req[0] |=> code_o == C_LINE);
   // R1: no request gives the idle code
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req == '0 |=> code_o == C_NONE);
endmodule

// File: rtl/fcr_ctrl.sv
module fcr_ctrl #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   generate
      if (W < 3) begin : g_bad_w
         $error("fcr_ctrl: width must be at least 3");
      end
   endgenerate

   logic qual;
   assign qual = wr && wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         if (wr) q[0] <= wdata[0];
         q[1] <= qual && wdata[1];
         if (qual) q[W-1:2] <= wdata[W-1:2];
      end
   end

   // R11: an unqualified write keeps the upper bits
   p_qual_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr && !wdata[0] |=> q[W-1:2] == $past(q[W-1:2]));
   // R12: the reset pulse lasts one cycle
   p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      q[1] && !qual |=> !q[1]);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int FCR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_line,
   input  logic             lvl_rxrdy,
   input  logic             lvl_rxtmo,
   input  logic             lvl_txe,
   input  logic             lvl_modem,
   input  logic             ev_match,
   input  logic             ev_xon,
   input  logic             ev_out_chg,
   input  logic             ev_in_chg,
   input  logic [6:0]       src_en,
   input  logic             ext_en,
   input  logic             stat_rd,
   input  logic             msr_rd,
   input  logic             fcr_wr,
   input  logic [FCR_W-1:0] fcr_wdata,
   output logic [7:0]       isr_byte,
   output logic             irq_n,
   output logic [FCR_W-1:0] fcr_cfg,
   output logic             rx_fifo_clr
);
   generate
      if (FCR_W != 8) begin : g_bad_fcr
         $error("uart_irq_ident: control byte must be 8 bits");
      end
   endgenerate

   logic sfc_q, ochg_q, ichg_q;
   logic [NUM_LVL-1:0] raw, eff;
   logic [CODE_W-1:0]  code;

   irq_flag #(.CLR_WINS(1'b1)) u_sfc (
      .clk(clk), .rst_n(rst_n), .set_i(ev_match), .clr_i(ev_xon), .q_o(sfc_q));
   irq_flag #(.CLR_WINS(1'b0)) u_ochg (
      .clk(clk), .rst_n(rst_n), .set_i(ev_out_chg), .clr_i(stat_rd), .q_o(ochg_q));
   irq_flag #(.CLR_WINS(1'b0)) u_ichg (
      .clk(clk), .rst_n(rst_n), .set_i(ev_in_chg), .clr_i(msr_rd), .q_o(ichg_q));

   assign raw = {ochg_q | ichg_q, sfc_q, lvl_modem, lvl_txe, lvl_rxtmo, lvl_rxrdy, lvl_line};

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LVL; gi++) begin : g_mask
         if (gi >= EXT_FIRST) begin : g_ext
            assign eff[gi] = raw[gi] & src_en[gi] & ext_en;
         end else begin : g_base
            assign eff[gi] = raw[gi] & src_en[gi];
         end
      end
   endgenerate

   irq_prio_enc #(.N(NUM_LVL)) u_enc (
      .clk(clk), .rst_n(rst_n), .req(eff), .code_o(code));

   fcr_ctrl #(.W(FCR_W)) u_fcr (
      .clk(clk), .rst_n(rst_n), .wr(fcr_wr), .wdata(fcr_wdata), .q(fcr_cfg));

   assign isr_byte    = {{2{fcr_cfg[0]}}, code};
   assign irq_n       = code[0];
   assign rx_fifo_clr = fcr_cfg[1];

   // R5: extended sources stay hidden while disabled
   p_ext_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_en |=> isr_byte[5:4] == 2'b00);
   // R1: any enabled source pulls the pending line low
   p_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|eff) |=> !irq_n);
   // R4: a disabled line error source is never encoded
   p_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !src_en[0] |=> isr_byte[5:0] != C_LINE);
endmodule

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lvl_line = 0, lvl_rxrdy = 0, lvl_rxtmo = 0, lvl_txe = 0, lvl_modem = 0;
   logic ev_match = 0, ev_xon = 0, ev_out_chg = 0, ev_in_chg = 0;
   logic [6:0] src_en = 7'h7F;
   logic ext_en = 0, stat_rd = 0, msr_rd = 0, fcr_wr = 0;
   logic [7:0] fcr_wdata = 8'h00;
   logic [7:0] isr_byte, fcr_cfg;
   logic irq_n, rx_fifo_clr;

   always #2.5 clk = ~clk;

   uart_irq_ident uut (
      .clk(clk), .rst_n(rst_n), .lvl_line(lvl_line), .lvl_rxrdy(lvl_rxrdy),
      .lvl_rxtmo(lvl_rxtmo), .lvl_txe(lvl_txe), .lvl_modem(lvl_modem),
      .ev_match(ev_match), .ev_xon(ev_xon), .ev_out_chg(ev_out_chg),
      .ev_in_chg(ev_in_chg), .src_en(src_en), .ext_en(ext_en), .stat_rd(stat_rd),
      .msr_rd(msr_rd), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata), .isr_byte(isr_byte),
      .irq_n(irq_n), .fcr_cfg(fcr_cfg), .rx_fifo_clr(rx_fifo_clr));

   typedef struct {
      logic [7:0] isr;
      logic       irqn;
      logic [7:0] fcr;
      string      tag;
   } exp_t;

   exp_t sb[$];
   int n_run = 0, n_fail = 0;
   logic m_sfc = 0, m_oc = 0, m_ic = 0;
   logic [7:0] m_fcr = 8'h00;

   function automatic logic [5:0] ref_code(input logic [6:0] e);
      if (e[0])      return 6'b000110;
      else if (e[1]) return 6'b000100;
      else if (e[2]) return 6'b001100;
      else if (e[3]) return 6'b000010;
      else if (e[4]) return 6'b000000;
      else if (e[5]) return 6'b010000;
      else if (e[6]) return 6'b100000;
      return 6'b000001;
   endfunction

   // driver: predicts the state one edge later, pushes it, steps the clock
   task automatic tick(input string tag);
      exp_t it;
      logic [6:0] e;
      logic [5:0] c;
      logic [7:0] f;
      e[0] = lvl_line & src_en[0];
      e[1] = lvl_rxrdy & src_en[1];
      e[2] = lvl_rxtmo & src_en[2];
      e[3] = lvl_txe & src_en[3];
      e[4] = lvl_modem & src_en[4];
      e[5] = m_sfc & src_en[5] & ext_en;
      e[6] = (m_oc | m_ic) & src_en[6] & ext_en;
      c = ref_code(e);
      f = m_fcr;
      f[1] = 1'b0;
      if (fcr_wr && fcr_wdata[0]) f = fcr_wdata;
      else if (fcr_wr) f[0] = 1'b0;
      m_sfc = ev_xon ? 1'b0 : (ev_match ? 1'b1 : m_sfc);
      m_oc  = ev_out_chg ? 1'b1 : (stat_rd ? 1'b0 : m_oc);
      m_ic  = ev_in_chg ? 1'b1 : (msr_rd ? 1'b0 : m_ic);
      m_fcr = f;
      it.isr = {{2{f[0]}}, c};
      it.irqn = c[0];
      it.fcr = f;
      it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // monitor: compares one item per edge, just after the edge
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t it;
         it = sb.pop_front();
         chk({it.tag, " isr"}, {24'd0, isr_byte}, {24'd0, it.isr});
         chk({it.tag, " irq_n"}, {31'd0, irq_n}, {31'd0, it.irqn});
         chk({it.tag, " fcr/rx_clr"}, {23'd0, rx_fifo_clr, fcr_cfg}, {23'd0, it.fcr[1], it.fcr});
      end
   end

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset isr", {24'd0, isr_byte}, 32'h01);
      chk("R1 reset irq_n/fcr", {23'd0, irq_n, fcr_cfg}, {23'd0, 1'b1, 8'h00});
      rst_n = 1'b1;
      tick("R1 idle");
      lvl_txe = 1; tick("R2 txe");
      lvl_line = 1; lvl_rxrdy = 1; tick("R3 line over rx/tx");
      lvl_line = 0; tick("R3 falls to rx");
      lvl_rxrdy = 0; tick("R3 falls to tx");
      lvl_txe = 0; lvl_rxtmo = 1; tick("R2 timeout");
      lvl_rxtmo = 0; lvl_modem = 1; tick("R2 modem");
      lvl_modem = 0; tick("R1 back to idle");
      src_en[1] = 0; lvl_rxrdy = 1; tick("R4 masked rx");
      lvl_txe = 1; tick("R4 masked rx lets tx");
      src_en[1] = 1; tick("R4 re-enabled rx");
      lvl_rxrdy = 0; lvl_txe = 0;
      ev_match = 1; tick("R5 match latched");
      ev_match = 0; tick("R5 masked no ext");
      tick("R5 masked holds");
      ext_en = 1; tick("R5 unmasked");
      stat_rd = 1; msr_rd = 1; tick("R6 reads keep");
      stat_rd = 0; msr_rd = 0; tick("R6 sticky");
      lvl_line = 1; tick("R3 line over match");
      lvl_line = 0; ev_xon = 1; tick("R6 xon clears");
      ev_xon = 0; tick("R6 cleared");
      ev_match = 1; ev_xon = 1; tick("R6 xon wins");
      ev_match = 0; ev_xon = 0; tick("R6 still clear");
      ev_out_chg = 1; tick("R7 out change");
      ev_out_chg = 0; tick("R7 pending");
      msr_rd = 1; tick("R8 msr leaves out flag");
      msr_rd = 0; stat_rd = 1; tick("R7 read shows source");
      stat_rd = 0; tick("R7 cleared");
      ev_in_chg = 1; tick("R8 in change");
      ev_in_chg = 0; stat_rd = 1; tick("R8 stat read keeps");
      stat_rd = 0; tick("R8 pending");
      msr_rd = 1; tick("R8 msr clears");
      msr_rd = 0; tick("R8 cleared");
      ev_out_chg = 1; stat_rd = 1; tick("R9 set with read");
      ev_out_chg = 0; stat_rd = 0; tick("R9 survived");
      ev_in_chg = 1; msr_rd = 1; tick("R9 in set with read");
      ev_in_chg = 0; msr_rd = 0; ext_en = 0; tick("R5 change masked");
      ext_en = 1; stat_rd = 1; msr_rd = 1; tick("R9 clear both");
      stat_rd = 0; msr_rd = 0; tick("R9 both cleared");
      fcr_wr = 1; fcr_wdata = 8'h01; tick("R10 fifo on");
      fcr_wdata = 8'hC3; tick("R12 rx clr pulse");
      fcr_wr = 0; tick("R12 self clear");
      fcr_wr = 1; fcr_wdata = 8'h0A; tick("R11 unqualified write");
      fcr_wr = 0; tick("R10 fifo off");
      fcr_wr = 1; fcr_wdata = 8'h3D; tick("R11 qualified write");
      fcr_wr = 0; lvl_txe = 1; tick("R10 fifo bits with tx");
      lvl_txe = 0; tick("R12 no pulse");
      repeat (2) @(negedge clk);
      summary();
      $finish;
   end
endmodule